// File: doc/BRIEF.md
# Block Lock Controller

This block keeps a write-protection state for every erase block of a flash array and changes those states on command. Software loads a first and a last block index into two range registers, then issues one of four commands: unlock a range, lock a range, make a range permanently locked ("lock-tight"), or unlock the whole array. The controller then walks the affected blocks in ascending order, one block per clock cycle, and updates each one according to the command's rules.

Lock-tight blocks cannot be changed by a lock or unlock command. Such a command stops as soon as it reaches a lock-tight block. The lock-tight command itself leaves unlocked blocks alone. A status register holds the state most recently written to any block. A busy flag covers the walk, and a one-cycle done pulse ends it. When the walk runs past the array's last block, an error pulse is issued together with done. A registered query port returns the state of any single block. Enforcing the protection on program or erase traffic is done elsewhere.

Top module: `blklock_ctrl`

## Requirements
- R1: When `rst` is high at a clock edge, the controller clears `busy`, `done`, `cmd_err` and both range registers, and sets `wp_status` to 3'b010. If `rst_cold` is also high, every block becomes locked. If `rst_cold` is low (warm reset), every block keeps its state.
- R2: Block states are one-hot: 3'b001 lock-tight, 3'b010 locked, 3'b100 unlocked. `blk_state` shows the state of block `blk_sel` one cycle after it is sampled, as held before that edge's update. For an index at or beyond `NUM_BLOCKS` it shows 3'b000.
- R3: A register write with `reg_wr_sel`=0 loads both range registers with the low `IDX_W` bits of `reg_wr_data`. With `reg_wr_sel`=1 it loads only the last-block register. `IDX_W` is ceil(log2(`NUM_BLOCKS`)).
- R4: Opcode 8'h23 (unlock) and opcode 8'h2A (lock) visit blocks from the first index to the last index inclusive and set each block to unlocked or locked. The walk ends at the first lock-tight block, and that block and all later blocks are left unchanged.
- R5: Opcode 8'h2C (lock-tight) visits the same range. It leaves unlocked blocks unchanged and sets every other block to lock-tight.
- R6: Opcode 8'h27 (unlock all) visits blocks 0 to `NUM_BLOCKS`-1 with the same stop-at-lock-tight rule as R4. It ignores the range registers.
- R7: A visited index at or beyond `NUM_BLOCKS` ends the walk. `cmd_err` is raised in the same cycle as `done`, and no block at or beyond that index is changed.
- R8: `wp_status` takes the new state of each block as it is written. Visiting a block that is skipped, or ending a walk at a lock-tight block, leaves `wp_status` unchanged.
- R9: `busy` rises in the cycle after an accepted command and stays high for one cycle per visited block. It falls together with a one-cycle `done` pulse. When the first index is greater than the last index, `busy` is high for one cycle and no block changes.
- R10: A command strobe while `busy` is high is ignored. An unknown opcode never raises `busy`: `done` and `cmd_err` pulse in the next cycle and no block changes.
- R11: If a range register write and a command strobe fall in the same cycle, the command uses the range held before that write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_cold | input | 1 | Qualifies `rst`: 1 = cold (all blocks locked), 0 = warm |
| reg_wr_en | input | 1 | Range register write strobe |
| reg_wr_sel | input | 1 | 0 = first-block register (also loads last), 1 = last-block register |
| reg_wr_data | input | DATA_W | Write data, low IDX_W bits used |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| blk_sel | input | IDX_W | Block index for the query port |
| range_start | output | IDX_W | First-block register |
| range_end | output | IDX_W | Last-block register |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| cmd_err | output | 1 | One-cycle error pulse, coincident with `done` |
| wp_status | output | 3 | State most recently written to a block |
| blk_state | output | 3 | Registered state of block `blk_sel` |

## Verification
Two events can land in the same cycle: a write to a range register and a command strobe. The bench issues both together and checks that the walk covers the old range, while the register read-back shows the new value. A strobe that arrives during a walk is the second collision. The bench raises a second command mid-walk and confirms that the final block states match a model in which only the first command ran. These checks run alongside a sweep over all first/last index pairs, including ranges past the array end and reversed ranges. Every result is compared block by block against an arithmetic model kept in the bench.

// File: rtl/blklock_pkg.sv
package blklock_pkg;

  typedef enum logic [2:0] {
    BS_NONE     = 3'b000,
    BS_TIGHT    = 3'b001,
    BS_LOCKED   = 3'b010,
    BS_UNLOCKED = 3'b100
  } blk_state_e;

  typedef enum logic [1:0] {
    SW_UNLOCK = 2'd0,
    SW_LOCK   = 2'd1,
    SW_TIGHT  = 2'd2
  } sweep_kind_e;

  localparam logic [7:0] OPC_UNLOCK     = 8'h23;
  localparam logic [7:0] OPC_UNLOCK_ALL = 8'h27;
  localparam logic [7:0] OPC_LOCK       = 8'h2A;
  localparam logic [7:0] OPC_TIGHT      = 8'h2C;

  typedef struct packed {
    logic        known;
    logic        whole;
    sweep_kind_e kind;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [7:0] op);
    op_dec_t d;
    d.known = 1'b1;
    d.whole = 1'b0;
    d.kind  = SW_UNLOCK;
    unique case (op)
      OPC_UNLOCK:     d.kind = SW_UNLOCK;
      OPC_UNLOCK_ALL: begin d.kind = SW_UNLOCK; d.whole = 1'b1; end
      OPC_LOCK:       d.kind = SW_LOCK;
      OPC_TIGHT:      d.kind = SW_TIGHT;
      default:        d.known = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/blklock_regs.sv
module blklock_regs #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [IDX_W-1:0]  first_q,
  output logic [IDX_W-1:0]  last_q
);

  logic [IDX_W-1:0] masked;
  logic             unused_hi;

  assign masked    = wr_data[IDX_W-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (wr_en) begin
      // a first-index write also seeds the last index
      if (!wr_sel) first_q <= masked;
      last_q <= masked;
    end
  end

endmodule

// File: rtl/blklock_array.sv
module blklock_array
  import blklock_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_cold,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  blk_state_e       wr_state,
  input  logic [IDX_W-1:0] rd_idx,
  output blk_state_e       rd_state,
  input  logic [IDX_W-1:0] q_idx,
  output blk_state_e       q_state
);

  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_BLOCKS);

  blk_state_e mem [NUM_BLOCKS];

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        if (rst_cold) mem[g] <= BS_LOCKED;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        mem[g] <= wr_state;
      end
    end
  end

  always_comb begin
    rd_state = BS_NONE;
    if ({1'b0, rd_idx} < LIMIT) rd_state = mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_state <= BS_NONE;
    end else if ({1'b0, q_idx} < LIMIT) begin
      q_state <= mem[q_idx];
    end else begin
      q_state <= BS_NONE;
    end
  end

endmodule

// File: rtl/blklock_seq.sv
module blklock_seq
  import blklock_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] cur_idx,
  input  blk_state_e       cur_state,
  output logic             wr_en,
  output blk_state_e       wr_state,
  output logic             busy,
  output logic             done,
  output logic             cmd_err,
  output blk_state_e       wp_status
);

  localparam logic [IDX_W:0]   LIMIT = (IDX_W+1)'(NUM_BLOCKS);
  localparam logic [IDX_W-1:0] TOP   = IDX_W'(NUM_BLOCKS - 1);

  sweep_kind_e      kind_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] end_q;
  op_dec_t          dec;
  logic             empty, beyond, tight_hit, skip, finish;

  assign dec     = decode_op(cmd_op);
  assign cur_idx = idx_q;

  always_comb begin
    empty     = idx_q > end_q;
    beyond    = ({1'b0, idx_q} >= LIMIT);
    tight_hit = (cur_state == BS_TIGHT);
    skip      = (kind_q == SW_TIGHT) ? (cur_state == BS_UNLOCKED) : tight_hit;
    wr_en     = busy && !empty && !beyond && !skip;
    unique case (kind_q)
      SW_UNLOCK: wr_state = BS_UNLOCKED;
      SW_LOCK:   wr_state = BS_LOCKED;
      default:   wr_state = BS_TIGHT;
    endcase
    finish = busy && (empty || beyond || (idx_q == end_q) ||
                      ((kind_q != SW_TIGHT) && tight_hit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      cmd_err   <= 1'b0;
      wp_status <= BS_LOCKED;
      kind_q    <= SW_UNLOCK;
      idx_q     <= '0;
      end_q     <= '0;
    end else begin
      done    <= 1'b0;
      cmd_err <= 1'b0;
      if (!busy && cmd_valid) begin
        if (dec.known) begin
          busy   <= 1'b1;
          kind_q <= dec.kind;
          idx_q  <= dec.whole ? '0  : first_idx;
          end_q  <= dec.whole ? TOP : last_idx;
        end else begin
          done    <= 1'b1;
          cmd_err <= 1'b1;
        end
      end
      if (busy) begin
        if (wr_en) wp_status <= wr_state;
        if (finish) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          cmd_err <= beyond && !empty;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/blklock_ctrl.sv
module blklock_ctrl
  import blklock_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int DATA_W     = 16,
  parameter int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_cold,
  input  logic              reg_wr_en,
  input  logic              reg_wr_sel,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [IDX_W-1:0]  blk_sel,
  output logic [IDX_W-1:0]  range_start,
  output logic [IDX_W-1:0]  range_end,
  output logic              busy,
  output logic              done,
  output logic              cmd_err,
  output logic [2:0]        wp_status,
  output logic [2:0]        blk_state
);

  logic [IDX_W-1:0] walk_idx;
  blk_state_e       walk_state, new_state, query_state, wp_q;
  logic             walk_wr;

  blklock_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_sel  (reg_wr_sel),
    .wr_data (reg_wr_data),
    .first_q (range_start),
    .last_q  (range_end)
  );

  blklock_array #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_array (
    .clk      (clk),
    .rst      (rst),
    .rst_cold (rst_cold),
    .wr_en    (walk_wr),
    .wr_idx   (walk_idx),
    .wr_state (new_state),
    .rd_idx   (walk_idx),
    .rd_state (walk_state),
    .q_idx    (blk_sel),
    .q_state  (query_state)
  );

  blklock_seq #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .first_idx (range_start),
    .last_idx  (range_end),
    .cur_idx   (walk_idx),
    .cur_state (walk_state),
    .wr_en     (walk_wr),
    .wr_state  (new_state),
    .busy      (busy),
    .done      (done),
    .cmd_err   (cmd_err),
    .wp_status (wp_q)
  );

  assign wp_status = wp_q;
  assign blk_state = query_state;

endmodule

// File: rtl/blklock_ctrl_chk.sv
module blklock_ctrl_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr_en,
  input logic             reg_wr_sel,
  input logic             cmd_valid,
  input logic [7:0]       cmd_op,
  input logic [IDX_W-1:0] range_start,
  input logic [IDX_W-1:0] range_end,
  input logic             busy,
  input logic             done,
  input logic             cmd_err,
  input logic [2:0]       wp_status,
  input logic [2:0]       blk_state
);

  logic known;
  assign known = (cmd_op == 8'h23) || (cmd_op == 8'h27) ||
                 (cmd_op == 8'h2A) || (cmd_op == 8'h2C);

  assert_start_seeds_end_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !reg_wr_sel) |=> (range_start == range_end));

  assert_status_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(wp_status) == 1);

  assert_query_encoding_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(blk_state) <= 1);

  assert_launch_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid && known) |=> busy);

  assert_busy_end_done_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> done);

  assert_unknown_op_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid && !known) |=> (!busy && done && cmd_err));

endmodule

bind blklock_ctrl blklock_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_sel  (reg_wr_sel),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .range_start (range_start),
  .range_end   (range_end),
  .busy        (busy),
  .done        (done),
  .cmd_err     (cmd_err),
  .wp_status   (wp_status),
  .blk_state   (blk_state)
);

// File: tb/test_blklock_ctrl.sv
module test_blklock_ctrl;

  localparam int N  = 12;
  localparam int IW = 4;
  localparam int DW = 16;
  localparam logic [2:0] T = 3'b001, L = 3'b010, U = 3'b100;

  logic          clk = 1'b0;
  logic          rst = 1'b1, rst_cold = 1'b1;
  logic          reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
  logic [DW-1:0] reg_wr_data = '0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_op = '0;
  logic [IW-1:0] blk_sel = '0;
  logic [IW-1:0] range_start, range_end;
  logic          busy, done, cmd_err;
  logic [2:0]    wp_status, blk_state;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [2:0] m [N];
  logic [2:0] mwp;
  int         ms, me;

  always #10 clk = ~clk;

  blklock_ctrl #(.NUM_BLOCKS(N), .DATA_W(DW)) i_blklock_ctrl (
    .clk(clk), .rst(rst), .rst_cold(rst_cold),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .blk_sel(blk_sel),
    .range_start(range_start), .range_end(range_end),
    .busy(busy), .done(done), .cmd_err(cmd_err),
    .wp_status(wp_status), .blk_state(blk_state)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit cold);
    @(negedge clk);
    rst = 1'b1; rst_cold = cold;
    @(negedge clk);
    rst = 1'b0; rst_cold = 1'b0;
    if (cold) for (int i = 0; i < N; i++) m[i] = L;
    mwp = L; ms = 0; me = 0;
    check(!busy && !done && !cmd_err, "R1", "flags after reset",
          {busy, done, cmd_err}, 0);
    check(wp_status == L, "R1", "wp_status after reset", wp_status, L);
    check(range_start == 0 && range_end == 0, "R1", "range after reset",
          {range_start, range_end}, 0);
  endtask

  task automatic wr_reg(input bit sel, input int data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = DW'(data);
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (!sel) ms = data % 16;
    me = data % 16;
    check(range_start == IW'(ms) && range_end == IW'(me), "R3", "range regs",
          {range_start, range_end}, {ms[3:0], me[3:0]});
  endtask

  task automatic check_blocks(input string req);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      blk_sel = IW'(i);
      @(negedge clk);
      check(blk_state == m[i], req, $sformatf("block %0d state", i),
            blk_state, m[i]);
    end
  endtask

  // Arithmetic model of one command; returns visited count and error flag.
  function automatic void model(input logic [7:0] op, input int lo_in,
                                input int hi_in, output int visits,
                                output bit err, output bit known);
    int lo, hi;
    logic [2:0] nv;
    visits = 0; err = 0;
    known = (op == 8'h23) || (op == 8'h27) || (op == 8'h2A) || (op == 8'h2C);
    if (!known) begin err = 1; return; end
    lo = (op == 8'h27) ? 0 : lo_in;
    hi = (op == 8'h27) ? N - 1 : hi_in;
    nv = (op == 8'h2A) ? L : (op == 8'h2C) ? T : U;
    if (lo > hi) begin visits = 1; return; end
    for (int i = lo; ; i++) begin
      visits++;
      if (i >= N) begin err = 1; break; end
      if (op == 8'h2C) begin
        if (m[i] != U) begin m[i] = T; mwp = T; end
      end else begin
        if (m[i] == T) break;
        m[i] = nv; mwp = nv;
      end
      if (i == hi) break;
    end
  endfunction

  task automatic finish_cmd(input string req, input int visits, input bit err);
    int n = 0;
    while (busy && n < 64) begin
      n++;
      @(negedge clk);
    end
    check(n == visits, "R9", $sformatf("%s busy cycles", req), n, visits);
    check(done, "R9", "done pulse at end", done, 1);
    check(cmd_err == err, "R7", $sformatf("%s cmd_err", req), cmd_err, err);
    check(wp_status == mwp, "R8", $sformatf("%s wp_status", req), wp_status, mwp);
  endtask

  task automatic run_cmd(input logic [7:0] op, input string req);
    int v; bit e, k;
    model(op, ms, me, v, e, k);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    finish_cmd(req, v, e);
    check_blocks(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int v; bit e, k;
    logic [7:0] ops [6];
    ops[0] = 8'h23; ops[1] = 8'h2A; ops[2] = 8'h2C;
    ops[3] = 8'h2A; ops[4] = 8'h23; ops[5] = 8'h27;
    for (int i = 0; i < N; i++) m[i] = L;

    // R1: cold reset locks everything
    repeat (2) @(negedge clk);
    do_reset(1'b1);
    check_blocks("R1");

    // R3: masking and start seeding end; end-only write
    wr_reg(1'b0, 16'h0035);
    wr_reg(1'b1, 16'h00F9);

    run_cmd(8'h23, "R4");                 // unlock 5..9
    wr_reg(1'b0, 3); wr_reg(1'b1, 7);
    run_cmd(8'h2C, "R5");                 // 3,4 tight; 5..7 skipped
    wr_reg(1'b0, 0); wr_reg(1'b1, 11);
    run_cmd(8'h2A, "R4");                 // lock 0..2, stop at 3
    run_cmd(8'h27, "R6");                 // unlock all, stop at 3
    wr_reg(1'b0, 10); wr_reg(1'b1, 14);
    run_cmd(8'h2A, "R7");                 // 10,11 locked, error at 12
    run_cmd(8'h55, "R10");                // unknown opcode
    wr_reg(1'b0, 8); wr_reg(1'b1, 2);
    run_cmd(8'h2A, "R9");                 // reversed range

    // R2: query beyond the array reads zero
    @(negedge clk); blk_sel = IW'(13);
    @(negedge clk);
    check(blk_state == 3'b000, "R2", "query beyond array", blk_state, 0);

    // R10: strobe while busy is ignored
    wr_reg(1'b0, 0); wr_reg(1'b1, 2);
    model(8'h2A, ms, me, v, e, k);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 8'h2A;
    @(negedge clk); cmd_op = 8'h27;       // still asserted while busy
    check(busy, "R10", "busy during walk", busy, 1);
    @(negedge clk); cmd_valid = 1'b0;
    finish_cmd("R10", v - 1, e);
    check_blocks("R10");

    // R11: range write and command in the same cycle
    wr_reg(1'b0, 8); wr_reg(1'b1, 9);
    model(8'h23, ms, me, v, e, k);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 8'h23;
    reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = 16'h0001;
    @(negedge clk);
    cmd_valid = 1'b0; reg_wr_en = 1'b0;
    check(range_start == 1 && range_end == 1, "R11", "range after collision",
          {range_start, range_end}, 8'h11);
    finish_cmd("R11", v, e);
    ms = 1; me = 1;
    check_blocks("R11");

    // R1: warm reset keeps block states
    do_reset(1'b0);
    check_blocks("R1");

    // Sweep over every first/last pair
    for (int s = 0; s < 16; s++) begin
      do_reset(1'b1);
      run_cmd(8'h27, "R6");
      for (int t = 0; t < 16; t++) begin
        wr_reg(1'b0, s | ((t + 1) << 8));
        wr_reg(1'b1, t | (s << 12));
        run_cmd(ops[(s * 3 + t) % 6], "R4");
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule